// File: doc/BRIEF.md
# Descriptor Chain Sequencer

This block walks a linked chain of 16-byte descriptors in memory on behalf of one DMA channel. For each descriptor it reads three words, decodes the operation, stream key and control modes, and hands a transfer request to an external data mover. When the mover reports completion, the block writes status and the residual count back into the fourth word of the descriptor. It then raises an interrupt, branches or waits, as the descriptor's mode fields select, and moves its command pointer to the next descriptor.

The channel status register lives here. Software-side control writes reach it through a masked write port, and the command pointer has its own load port. Three select bytes, one each for the interrupt, branch and wait conditions, are plain inputs from the register block. Memory requests and transfer requests are valid/ready streams. A request stays asserted with stable fields until the cycle in which ready is high. Read responses (one per read, in order) and transfer completions carry no ready and are always accepted. Writes return no response.

Top module: `desc_chain_seq`

## Requirements
- R1: While status RUN (bit 15) and ACTIVE (bit 10) are both set and the block is idle, it reads the descriptor words at pointer+0, +4 and +8. Word 0 holds the command in [31:16] and the request count in [15:0], word 1 the data address and word 2 the command-dependent word. A memory request holds its address until accepted.
- R2: Operations (command bits 15:12) 0 to 3 start a transfer. Bit 13 set means the data moves into memory, bit 12 set marks a last-type command. The transfer carries key (command bits 10:8), data address and request count, and it holds until accepted.
- R3: On completion the block writes pointer+12 with the status register in [31:16] and the residual in [15:0]. The residual is the mover's count for transfers and 0 for a no-op (operation 6).
- R4: With wait mode (command bits 1:0) selecting a true condition, the block makes no write-back, keeps the pointer and stays active until the condition turns false, then completes normally.
- R5: Interrupt mode (command bits 5:4) raises the interrupt after write-back when it is 3, or when it is 1 with a true condition, or when it is 2 with a false condition. Mode 0 never raises it.
- R6: Branch mode (command bits 3:2), with the same encoding, when taken loads the pointer from the command-dependent word with bits 3:0 cleared and sets BT (bit 8). Otherwise it adds 16 to the pointer and clears BT.
- R7: A condition is true when (status[3:0] AND sel[7:4]) equals (sel[3:0] AND sel[7:4]). Each condition uses its own select byte.
- R8: After the write-back of a last-type command, FLUSH (bit 13) is cleared; a non-last command leaves it set.
- R9: WAKE (bit 12) is cleared when a descriptor fetch begins.
- R10: Stop (operation 7) clears ACTIVE, DEAD (bit 11) and FLUSH, writes nothing back and leaves the pointer unchanged.
- R11: A transfer command with key above 3 or a zero data address, or operation 4, 5 or above 7, kills the channel. DEAD is set, ACTIVE cleared, the interrupt raised, and no transfer or write-back takes place.
- R12: A control write updates the status bits selected by the mask among 15:12 and 7:0. Then WAKE or RUN sets ACTIVE, RUN clears DEAD, PAUSE (bit 14) clears ACTIVE, and a write that clears RUN also clears ACTIVE and DEAD.
- R13: A pointer load is ignored while RUN or ACTIVE is set; otherwise the pointer takes the value with bits 3:0 cleared.
- R14: The interrupt output is a level that stays high until an acknowledge cycle in which no new interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_mask | input | 16 | Bits of the status register to update |
| ctl_value | input | 16 | New values for the masked bits |
| cp_we | input | 1 | Command pointer load strobe |
| cp_wdata | input | ADDR_W | Command pointer load value |
| int_sel | input | 8 | Interrupt condition select {mask, value} |
| br_sel | input | 8 | Branch condition select {mask, value} |
| wait_sel | input | 8 | Wait condition select {mask, value} |
| status | output | 16 | Channel status register |
| cmd_ptr | output | ADDR_W | Current descriptor address |
| irq | output | 1 | Interrupt level |
| irq_ack | input | 1 | Interrupt acknowledge |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Transfer request accepted |
| xfer_to_mem | output | 1 | Data moves from stream into memory |
| xfer_last | output | 1 | Last-type transfer |
| xfer_key | output | 3 | Stream key |
| xfer_addr | output | ADDR_W | Data address |
| xfer_len | output | 16 | Requested byte count |
| done_valid | input | 1 | Transfer completed |
| done_residual | input | 16 | Bytes not transferred |

## Verification
The chains cover several cases. A plain chain of output and input transfers ending in a stop separates sequential pointer advance from branching, and last-type from non-last FLUSH handling. A no-op chain with conditional branch and interrupt modes, under a fixed device status, shows whether the masked comparison and its true/false polarity are decoded correctly. An unaligned branch target checks the pointer alignment. A wait-if-true descriptor, held until the device status changes, tells a real stall apart from a premature write-back. Killing descriptors (reserved key, zero address) and control writes with RUN, PAUSE and WAKE separate the DEAD/ACTIVE rules. Memory and transfer ready toggle throughout to exercise the hold rules.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 16;
  localparam int ST_W   = 16;
  localparam int SEL_W  = 8;
  localparam int NCOND  = 3;  // 0: interrupt, 1: branch, 2: wait

  localparam int B_RUN   = 15;
  localparam int B_PAUSE = 14;
  localparam int B_FLUSH = 13;
  localparam int B_WAKE  = 12;
  localparam int B_DEAD  = 11;
  localparam int B_ACT   = 10;
  localparam int B_BT    = 8;
  localparam logic [ST_W-1:0] CTL_WR_MASK = 16'hF0FF;

  typedef enum logic [1:0] {M_NEVER, M_IF_T, M_IF_F, M_ALWAYS} cmode_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_XREQ, S_XWAIT, S_HOLD, S_WB, S_POST
  } seq_st_t;
endpackage

// File: rtl/dcs_cond.sv
module dcs_cond
  import dcs_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] sel,
  input  logic [3:0]       devstat,
  output logic             hit
);
  logic match;
  always_comb begin
    match = ((devstat & sel[7:4]) == (sel[3:0] & sel[7:4]));
    case (cmode_t'(mode))
      M_NEVER:  hit = 1'b0;
      M_IF_T:   hit = match;
      M_IF_F:   hit = !match;
      default:  hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/dcs_status.sv
module dcs_status
  import dcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_we,
  input  logic [ST_W-1:0] ctl_mask,
  input  logic [ST_W-1:0] ctl_value,
  input  logic            clr_wake,
  input  logic            clr_flush,
  input  logic            do_stop,
  input  logic            do_kill,
  input  logic            set_bt,
  input  logic            clr_bt,
  output logic [ST_W-1:0] st
);
  logic [ST_W-1:0] nx, m;

  always_comb begin
    nx = st;
    m  = ctl_mask & CTL_WR_MASK;
    if (ctl_we) begin
      nx = (ctl_value & m) | (st & ~m);
      if (nx[B_WAKE]) nx[B_ACT] = 1'b1;
      if (nx[B_RUN]) begin
        nx[B_ACT]  = 1'b1;
        nx[B_DEAD] = 1'b0;
      end
      if (nx[B_PAUSE]) nx[B_ACT] = 1'b0;
      if (st[B_RUN] && !nx[B_RUN]) begin
        nx[B_ACT]  = 1'b0;
        nx[B_DEAD] = 1'b0;
      end
    end
    if (clr_wake)  nx[B_WAKE]  = 1'b0;
    if (clr_flush) nx[B_FLUSH] = 1'b0;
    if (do_stop) begin
      nx[B_ACT]   = 1'b0;
      nx[B_DEAD]  = 1'b0;
      nx[B_FLUSH] = 1'b0;
    end
    if (do_kill) begin
      nx[B_DEAD] = 1'b1;
      nx[B_ACT]  = 1'b0;
    end
    if (set_bt) nx[B_BT] = 1'b1;
    if (clr_bt) nx[B_BT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= '0;
    else        st <= nx;
  end

  // R11
  kill_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_kill |=> (st[B_DEAD] && !st[B_ACT]));

  // R10
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_stop |=> (!st[B_ACT] && !st[B_DEAD] && !st[B_FLUSH]));
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
  import dcs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [ST_W-1:0]      ctl_mask,
  input  logic [ST_W-1:0]      ctl_value,
  input  logic                 cp_we,
  input  logic [ADDR_W-1:0]    cp_wdata,
  input  logic [SEL_W-1:0]     int_sel,
  input  logic [SEL_W-1:0]     br_sel,
  input  logic [SEL_W-1:0]     wait_sel,
  output logic [ST_W-1:0]      status,
  output logic [ADDR_W-1:0]    cmd_ptr,
  output logic                 irq,
  input  logic                 irq_ack,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_we,
  output logic [ADDR_W-1:0]    mem_req_addr,
  output logic [WORD_W-1:0]    mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [WORD_W-1:0]    mem_rsp_data,
  output logic                 xfer_valid,
  input  logic                 xfer_ready,
  output logic                 xfer_to_mem,
  output logic                 xfer_last,
  output logic [2:0]           xfer_key,
  output logic [ADDR_W-1:0]    xfer_addr,
  output logic [CNT_W-1:0]     xfer_len,
  input  logic                 done_valid,
  input  logic [CNT_W-1:0]     done_residual
);
  localparam int          FETCH_N = 3;
  localparam logic [1:0]  LAST_RD = 2'(FETCH_N - 1);
  localparam int          DESC_B  = 16;

  seq_st_t state;
  logic [1:0] rq_n, rs_n;
  logic [WORD_W-1:0] w0, w1, w2;
  logic [CNT_W-1:0]  resid;
  logic [3:0] op;
  logic [2:0] key;
  logic [NCOND-1:0][1:0]       modes;
  logic [NCOND-1:0][SEL_W-1:0] sels;
  logic [NCOND-1:0]            hit;
  logic running, io_bad, bad_cmd;
  logic clr_wake, clr_flush, do_stop, do_kill, set_bt, clr_bt, raise;
  logic unused_bits;

  assign op      = w0[31:28];
  assign key     = w0[26:24];
  assign modes   = {w0[17:16], w0[19:18], w0[21:20]};
  assign sels    = {wait_sel, br_sel, int_sel};
  assign running = status[B_RUN] && status[B_ACT];
  assign io_bad  = (key > 3'd3) || (w1 == '0);
  assign bad_cmd = (op <= 4'd3) ? io_bad : (op != 4'd6 && op != 4'd7);
  assign unused_bits = ^{w0[27], w0[23:22], w2[3:0]};

  for (genvar g = 0; g < NCOND; g++) begin : g_cond
    dcs_cond u_cond (
      .mode(modes[g]), .sel(sels[g]), .devstat(status[3:0]), .hit(hit[g])
    );
  end

  assign clr_wake  = (state == S_IDLE) && running;
  assign do_kill   = (state == S_DECODE) && bad_cmd;
  assign do_stop   = (state == S_DECODE) && (op == 4'd7);
  assign clr_flush = (state == S_POST) && (op == 4'd1 || op == 4'd3);
  assign set_bt    = (state == S_POST) && hit[1];
  assign clr_bt    = (state == S_POST) && !hit[1];
  assign raise     = do_kill || ((state == S_POST) && hit[0]);

  dcs_status u_status (
    .clk, .rst_n, .ctl_we, .ctl_mask, .ctl_value,
    .clr_wake, .clr_flush, .do_stop, .do_kill, .set_bt, .clr_bt,
    .st(status)
  );

  always_comb begin
    mem_req_valid = ((state == S_FETCH) && (rq_n != 2'(FETCH_N))) || (state == S_WB);
    mem_req_we    = (state == S_WB);
    mem_req_addr  = (state == S_WB) ? cmd_ptr + ADDR_W'(12)
                                    : cmd_ptr + ADDR_W'({rq_n, 2'b00});
    mem_req_wdata = {status, resid};
    xfer_valid    = (state == S_XREQ);
    xfer_to_mem   = op[1];
    xfer_last     = op[0];
    xfer_key      = key;
    xfer_addr     = w1[ADDR_W-1:0];
    xfer_len      = w0[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      rq_n  <= '0;
      rs_n  <= '0;
      w0    <= '0;
      w1    <= '0;
      w2    <= '0;
      resid <= '0;
      cmd_ptr <= '0;
      irq   <= 1'b0;
    end else begin
      if (raise)        irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;

      if (state == S_POST)
        cmd_ptr <= hit[1] ? {w2[ADDR_W-1:4], 4'b0000} : cmd_ptr + ADDR_W'(DESC_B);
      else if (cp_we && !status[B_RUN] && !status[B_ACT])
        cmd_ptr <= {cp_wdata[ADDR_W-1:4], 4'b0000};

      case (state)
        S_IDLE: begin
          rq_n <= '0;
          rs_n <= '0;
          if (running) state <= S_FETCH;
        end
        S_FETCH: begin
          if (mem_req_valid && mem_req_ready) rq_n <= rq_n + 2'd1;
          if (mem_rsp_valid) begin
            rs_n <= rs_n + 2'd1;
            case (rs_n)
              2'd0:    w0 <= mem_rsp_data;
              2'd1:    w1 <= mem_rsp_data;
              default: w2 <= mem_rsp_data;
            endcase
            if (rs_n == LAST_RD) state <= S_DECODE;
          end
        end
        S_DECODE: begin
          resid <= '0;
          if (bad_cmd || op == 4'd7) state <= S_IDLE;
          else if (op <= 4'd3)       state <= S_XREQ;
          else                       state <= S_HOLD;
        end
        S_XREQ:  if (xfer_ready) state <= S_XWAIT;
        S_XWAIT: if (done_valid) begin
          resid <= done_residual;
          state <= S_HOLD;
        end
        S_HOLD:  if (!hit[2]) state <= S_WB;
        S_WB:    if (mem_req_ready) state <= S_POST;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R14
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  // R13
  ptr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_we && (status[B_RUN] || status[B_ACT]) && state != S_POST)
      |=> (cmd_ptr == $past(cmd_ptr)));

  // R1
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R2
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_len)));

  // R6
  branch_bt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POST && hit[1]) |=> status[B_BT]);
endmodule

// File: tb/sim_desc_chain_seq.sv
`timescale 1ns/1ps
module sim_desc_chain_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        ctl_we = 0, cp_we = 0, irq_ack = 0;
  logic [15:0] ctl_mask = 0, ctl_value = 0;
  logic [31:0] cp_wdata = 0;
  logic [7:0]  int_sel = 0, br_sel = 0, wait_sel = 0;
  logic [15:0] status;
  logic [31:0] cmd_ptr;
  logic        irq;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        xfer_valid, xfer_ready, xfer_to_mem, xfer_last;
  logic [2:0]  xfer_key;
  logic [31:0] xfer_addr;
  logic [15:0] xfer_len;
  logic        done_valid = 0;
  logic [15:0] done_residual = 0;

  desc_chain_seq u0 (.*);

  int n_chk = 0, n_fail = 0, n_xfer = 0;
  logic [63:0] wb_q[$];
  logic [52:0] xf_q[$];
  logic [31:0] mem [0:255];
  logic [1:0]  rcnt;

  always @(posedge clk) begin
    if (!rst_n) rcnt <= 2'd0;
    else        rcnt <= rcnt + 2'd1;
  end
  assign mem_req_ready = (rcnt != 2'd3);
  assign xfer_ready    = rcnt[0];

  // memory model, one-cycle read latency
  always @(posedge clk) begin
    mem_rsp_valid <= rst_n && mem_req_valid && mem_req_ready && !mem_req_we;
    mem_rsp_data  <= mem[mem_req_addr[9:2]];
    if (rst_n && mem_req_valid && mem_req_ready && mem_req_we)
      mem[mem_req_addr[9:2]] <= mem_req_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor for descriptor write-backs (R3)
  always @(negedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready && mem_req_we) begin
      if (wb_q.size() == 0) chk("R3 unexpected write-back", mem_req_addr, 32'hFFFF_FFFF);
      else begin
        logic [63:0] e;
        e = wb_q.pop_front();
        chk("R3 write-back address", mem_req_addr, e[63:32]);
        chk("R3 write-back data", mem_req_wdata, e[31:0]);
      end
    end
  end

  // data mover model with transfer scoreboard (R2)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && xfer_valid && xfer_ready) begin
        logic [15:0] len;
        n_xfer++;
        len = xfer_len;
        if (xf_q.size() == 0) chk("R2 unexpected transfer", xfer_addr, 32'hFFFF_FFFF);
        else begin
          logic [52:0] e;
          e = xf_q.pop_front();
          chk("R2 transfer direction/last/key", {27'd0, xfer_to_mem, xfer_last, xfer_key}, {27'd0, e[52:48]});
          chk("R2 transfer address", xfer_addr, e[47:16]);
          chk("R2 transfer length", {16'd0, xfer_len}, {16'd0, e[15:0]});
        end
        repeat (3) @(negedge clk);
        done_valid = 1'b1;
        done_residual = len >> 1;
        @(negedge clk);
        done_valid = 1'b0;
      end
    end
  end

  task automatic ctl(input logic [15:0] m, input logic [15:0] v);
    @(negedge clk); ctl_we = 1; ctl_mask = m; ctl_value = v;
    @(negedge clk); ctl_we = 0;
  endtask
  task automatic setptr(input logic [31:0] p);
    @(negedge clk); cp_we = 1; cp_wdata = p;
    @(negedge clk); cp_we = 0;
  endtask
  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask
  task automatic desc(input logic [31:0] a, input logic [31:0] x0, input logic [31:0] x1, input logic [31:0] x2);
    mem[a[9:2]] = x0; mem[a[9:2]+1] = x1; mem[a[9:2]+2] = x2; mem[a[9:2]+3] = 32'hDEAD_BEEF;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!status[10]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset status", {16'd0, status}, 32'h0);
    chk("R13 reset pointer", cmd_ptr, 32'h0);
    chk("R14 reset irq", {31'd0, irq}, 32'h0);

    // A: plain chain, output-more key 2, input-last int always, stop
    desc(32'h100, 32'h0200_0008, 32'h200, 32'h0);
    desc(32'h110, 32'h3030_0004, 32'h240, 32'h0);
    desc(32'h120, 32'h7000_0000, 32'h0, 32'h0);
    setptr(32'h100);
    chk("R13 pointer load", cmd_ptr, 32'h100);
    xf_q.push_back({1'b0, 1'b0, 3'd2, 32'h200, 16'd8});
    xf_q.push_back({1'b1, 1'b1, 3'd0, 32'h240, 16'd4});
    wb_q.push_back({32'h10C, 16'hA400, 16'h0004});   // R8 FLUSH kept on non-last
    wb_q.push_back({32'h11C, 16'hA400, 16'h0002});
    ctl(16'hA000, 16'hA000);
    wait_idle();
    chk("R8 R10 status after last-type and stop", {16'd0, status}, 32'h8000);
    chk("R10 stop keeps pointer", cmd_ptr, 32'h120);
    chk("R5 interrupt always", {31'd0, irq}, 32'h1);
    chk("R3 all write-backs seen", wb_q.size(), 0);
    setptr(32'h300);
    chk("R13 load ignored while RUN", cmd_ptr, 32'h120);
    ack();
    chk("R14 irq cleared by ack", {31'd0, irq}, 32'h0);

    // B: conditional branch and interrupt with devstat 5
    ctl(16'h8000, 16'h0000);
    chk("R12 clearing RUN", {16'd0, status}, 32'h0);
    setptr(32'h140);
    ctl(16'h00FF, 16'h0005);
    br_sel = 8'hF5; int_sel = 8'hF5;
    desc(32'h140, 32'h6024_0000, 32'h0, 32'h185);
    desc(32'h180, 32'h6008_0000, 32'h0, 32'h300);
    desc(32'h190, 32'h7000_0000, 32'h0, 32'h0);
    wb_q.push_back({32'h14C, 16'h8405, 16'h0000});
    wb_q.push_back({32'h18C, 16'h8505, 16'h0000});   // R6 BT set by taken branch
    ctl(16'h8000, 16'h8000);
    wait_idle();
    chk("R6 R7 branch taken then not taken", cmd_ptr, 32'h190);
    chk("R6 BT cleared by sequential advance", {16'd0, status}, 32'h8005);
    chk("R5 R7 if-clear with true condition", {31'd0, irq}, 32'h0);

    // C: wait-if-true stall, WAKE cleared at fetch
    ctl(16'h8000, 16'h0000);
    setptr(32'h1C0);
    wait_sel = 8'h11; int_sel = 8'h10;
    desc(32'h1C0, 32'h6011_0000, 32'h0, 32'h0);
    desc(32'h1D0, 32'h7000_0000, 32'h0, 32'h0);
    ctl(16'h9000, 16'h9000);
    repeat (60) @(negedge clk);
    chk("R9 WAKE cleared, R4 still active", {16'd0, status}, 32'h8405);
    chk("R4 pointer held in wait", cmd_ptr, 32'h1C0);
    chk("R4 no interrupt in wait", {31'd0, irq}, 32'h0);
    wb_q.push_back({32'h1CC, 16'h8404, 16'h0000});
    ctl(16'h00FF, 16'h0004);
    wait_idle();
    chk("R4 completes after condition clears", cmd_ptr, 32'h1D0);
    chk("R5 R7 if-set interrupt", {31'd0, irq}, 32'h1);
    chk("R4 write-back done", wb_q.size(), 0);
    ack();

    // D: kill on key 4, then on zero address
    ctl(16'h8000, 16'h0000);
    setptr(32'h220);
    desc(32'h220, 32'h2400_0004, 32'h300, 32'h0);
    begin
      int nx0;
      nx0 = n_xfer;
      ctl(16'h8000, 16'h8000);
      wait_idle();
      chk("R11 key 4 kills", {16'd0, status}, 32'h8804);
      chk("R11 kill keeps pointer", cmd_ptr, 32'h220);
      chk("R11 kill raises irq", {31'd0, irq}, 32'h1);
      ack();
      ctl(16'h8000, 16'h0000);
      chk("R12 RUN clear removes DEAD", {16'd0, status}, 32'h0004);
      setptr(32'h230);
      desc(32'h230, 32'h1000_0010, 32'h0, 32'h0);
      ctl(16'h8000, 16'h8000);
      wait_idle();
      chk("R11 zero address kills", {16'd0, status}, 32'h8804);
      chk("R11 kill irq again", {31'd0, irq}, 32'h1);
      chk("R11 no transfer started", n_xfer, nx0);
    end

    // E: PAUSE overrides RUN
    ctl(16'h8000, 16'h0000);
    ctl(16'hC000, 16'hC000);
    chk("R12 PAUSE keeps ACTIVE clear", {16'd0, status}, 32'hC004);
    repeat (10) @(negedge clk);
    chk("R1 no fetch while paused", cmd_ptr, 32'h230);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule